// File: doc/BRIEF.md
# Driver Impedance Calibration Controller

This block produces the digital leg-select code for an output driver whose strength is trimmed against an external precision resistor. An analog comparator outside the block reports whether the driver is currently stronger or weaker than the target. The target is one fifth of the external resistor. The controller turns that single bit into a multi-bit code. A larger code enables more legs, so a larger code gives a stronger driver and a lower impedance.

After reset the code sits at mid-scale. The controller then runs a successive-approximation search, most significant bit first, with one comparator decision per fixed interval. The search always ends well inside a 1024-cycle budget, and at its end a calibrated flag goes high. From then on the controller tracks supply and temperature drift: at every update interval it moves the code by exactly one step toward the target and saturates at both ends of the range.

A strap input shows that the reference pin is tied to the I/O supply. While the strap is high, the controller holds the all-ones code, which is the minimum impedance, and ignores the comparator. When the strap drops, a fresh search starts. The asynchronous reset and both inputs pass through synchronizers of `SYNC_STAGES` flops.

Top module: `zcal_ctrl`

## Requirements
- R1: While reset is asserted, and after release until the first decision, the code is mid-scale (32 for a 6-bit code, only the top bit set) and `cal_done_o` is 0.
- R2: The search decides one bit per `STEP_CYC` cycles, starting with the top bit. At each decision, a comparator value of 1 ("driver stronger") clears the bit under trial and the next lower bit is set for trial. The first decision falls on the `SYNC_STAGES + STEP_CYC`-th clock edge after reset release. The final code is the largest code for which the comparator reads 0.
- R3: `cal_done_o` rises on the edge of the last search decision, `SYNC_STAGES + CODE_W*STEP_CYC` edges after reset release (98 with the defaults, inside the 1024-cycle budget). It then stays high through tracking. Only reset or the release of the strap clears it.
- R4: In tracking, the code changes only once every `TRACK_CYC` edges, counted from the end of the search. Each change is one step: up by one when the comparator reads 0, down by one when it reads 1.
- R5: In tracking, the code saturates. It holds at 0 while the comparator reads 1, and at all-ones (63) while the comparator reads 0. It never wraps.
- R6: With the strap at 1, the code becomes all-ones (63) and `cal_done_o` becomes 1 on the (`SYNC_STAGES`+1)-th edge. Both stay there whatever the comparator reads.
- R7: When the strap returns to 0, the code returns to mid-scale and `cal_done_o` to 0 on the (`SYNC_STAGES`+1)-th edge. A complete new search follows, and `cal_done_o` rises `CODE_W*STEP_CYC` edges after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmp_strong_i | input | 1 | Comparator: 1 = driver stronger than target, 0 = weaker |
| ref_tied_hi_i | input | 1 | Strap: reference pin tied to the I/O supply |
| imp_code_o | output | CODE_W | Driver leg-select code; larger is stronger |
| cal_done_o | output | 1 | Calibrated flag |

## Verification
The bench builds the controller with a 6-bit code, a 16-cycle decision interval and two synchronizer stages, as in the defaults. It shortens the tracking interval from 256 to 32 cycles, so single-step moves and saturation at both ends of the range are reached within a few dozen cycles. Because one search takes only 98 cycles, eight targets can be run from reset. Together they cover both ends of the code range and the two codes on either side of mid-scale, where the first decision flips.

// File: rtl/zcal_pkg.sv
package zcal_pkg;

  typedef enum logic [1:0] {
    ZC_SEARCH = 2'd0,
    ZC_TRACK  = 2'd1,
    ZC_FORCE  = 2'd2
  } zc_state_e;

endpackage

// File: rtl/zcal_sync.sv
module zcal_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_n;

  always_comb begin
    stg_n[0] = d_i;
    for (int i = 1; i < STAGES; i++) begin
      stg_n[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge arst_ni) begin
    if (!arst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_n;
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/zcal_timer.sv
module zcal_timer #(
  parameter int STEP_CYC  = 16,
  parameter int TRACK_CYC = 256
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic track_i,
  output logic tick_o
);

  localparam int LONG  = (STEP_CYC > TRACK_CYC) ? STEP_CYC : TRACK_CYC;
  localparam int CNT_W = (LONG > 2) ? $clog2(LONG) : 1;
  localparam logic [CNT_W-1:0] STEP_LD  = CNT_W'(STEP_CYC - 1);
  localparam logic [CNT_W-1:0] TRACK_LD = CNT_W'(TRACK_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic             cnt_en;

  assign tick_o = (cnt_q == '0);
  assign cnt_en = 1'b1;

  always_comb begin
    cnt_n = cnt_q;
    if (restart_i) begin
      cnt_n = STEP_LD;
    end else if (tick_o) begin
      cnt_n = track_i ? TRACK_LD : STEP_LD;
    end else begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= STEP_LD;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

endmodule

// File: rtl/zcal_core.sv
module zcal_core
  import zcal_pkg::*;
#(
  parameter int CODE_W    = 6,
  parameter int TRACK_CYC = 256,
  parameter int BUDGET    = 1024
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cmp_strong_i,
  input  logic              strap_i,
  output logic              restart_o,
  output logic              track_o,
  output logic [CODE_W-1:0] code_o,
  output logic              done_o
);

  localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [CODE_W-1:0] MID  = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] MAXC = '1;
  localparam logic [IDX_W-1:0]  TOP_IDX = IDX_W'(CODE_W - 1);

  zc_state_e         state_q, state_n;
  logic [CODE_W-1:0] code_q, code_n;
  logic [IDX_W-1:0]  idx_q, idx_n, idx_dn;
  logic              done_q, done_n;
  logic              restart;

  assign idx_dn = idx_q - 1'b1;

  // Next-state logic: strap has priority, then search or tracking per tick.
  always_comb begin
    state_n = state_q;
    code_n  = code_q;
    idx_n   = idx_q;
    done_n  = done_q;
    restart = 1'b0;
    if (strap_i) begin
      state_n = ZC_FORCE;
      code_n  = MAXC;
      done_n  = 1'b1;
      restart = 1'b1;
    end else begin
      case (state_q)
        ZC_FORCE: begin
          state_n = ZC_SEARCH;
          code_n  = MID;
          idx_n   = TOP_IDX;
          done_n  = 1'b0;
          restart = 1'b1;
        end
        ZC_SEARCH: begin
          if (tick_i) begin
            if (cmp_strong_i) begin
              code_n[idx_q] = 1'b0;
            end
            if (idx_q != '0) begin
              code_n[idx_dn] = 1'b1;
              idx_n          = idx_dn;
            end else begin
              state_n = ZC_TRACK;
              done_n  = 1'b1;
            end
          end
        end
        ZC_TRACK: begin
          if (tick_i) begin
            if (cmp_strong_i) begin
              if (code_q != '0) code_n = code_q - 1'b1;
            end else begin
              if (code_q != MAXC) code_n = code_q + 1'b1;
            end
          end
        end
        default: begin
          state_n = ZC_SEARCH;
          code_n  = MID;
          idx_n   = TOP_IDX;
          done_n  = 1'b0;
          restart = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ZC_SEARCH;
      code_q  <= MID;
      idx_q   <= TOP_IDX;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      code_q  <= code_n;
      idx_q   <= idx_n;
      done_q  <= done_n;
    end
  end

  assign restart_o = restart;
  assign track_o   = (state_n == ZC_TRACK);
  assign code_o    = code_q;
  assign done_o    = done_q;

  // Reference counters used only by the checks below.
  localparam int BW = $clog2(BUDGET) + 1;
  localparam int GW = (TRACK_CYC > 2) ? $clog2(TRACK_CYC) : 1;
  logic [BW-1:0] srch_cnt_q, srch_cnt_n;
  logic [GW-1:0] gap_q, gap_n;

  always_comb begin
    srch_cnt_n = '0;
    if (state_q == ZC_SEARCH) begin
      srch_cnt_n = (srch_cnt_q == BW'(BUDGET)) ? srch_cnt_q : srch_cnt_q + 1'b1;
    end
    gap_n = '0;
    if (state_q == ZC_TRACK) begin
      gap_n = (gap_q == GW'(TRACK_CYC - 1)) ? '0 : gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      srch_cnt_q <= '0;
      gap_q      <= '0;
    end else begin
      srch_cnt_q <= srch_cnt_n;
      gap_q      <= gap_n;
    end
  end

  // R3
  search_budget_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    srch_cnt_q < BW'(BUDGET));

  // R3
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(done_q) |-> $past(state_q) == ZC_FORCE);

  // R4
  track_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ZC_TRACK && !strap_i) |=>
      (code_q == $past(code_q) ||
       code_q == CODE_W'($past(code_q) + 1'b1) ||
       code_q == CODE_W'($past(code_q) - 1'b1)));

  // R4
  track_period_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ZC_TRACK && $past(state_q) == ZC_TRACK && code_q != $past(code_q))
      |-> $past(gap_q) == GW'(TRACK_CYC - 1));

  // R5
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ZC_TRACK && !strap_i && (code_q == '0 || code_q == MAXC)) |=>
      (code_q <= CODE_W'(1) || code_q >= MAXC - 1'b1));

  // R6
  strap_force_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    strap_i |=> (code_q == MAXC && done_q));

  // R7
  strap_exit_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ZC_FORCE && !strap_i) |=> (code_q == MID && !done_q));

endmodule

// File: rtl/zcal_ctrl.sv
module zcal_ctrl #(
  parameter int CODE_W      = 6,
  parameter int STEP_CYC    = 16,
  parameter int TRACK_CYC   = 256,
  parameter int SYNC_STAGES = 2,
  parameter int BUDGET      = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_strong_i,
  input  logic              ref_tied_hi_i,
  output logic [CODE_W-1:0] imp_code_o,
  output logic              cal_done_o
);

  logic       rst_int_n;
  logic [1:0] in_sync;
  logic       tick;
  logic       restart;
  logic       track;

  zcal_sync #(
    .WIDTH  (1),
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk     (clk),
    .arst_ni (rst_n),
    .d_i     (1'b1),
    .q_o     (rst_int_n)
  );

  zcal_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_in_sync (
    .clk     (clk),
    .arst_ni (rst_int_n),
    .d_i     ({ref_tied_hi_i, cmp_strong_i}),
    .q_o     (in_sync)
  );

  zcal_timer #(
    .STEP_CYC  (STEP_CYC),
    .TRACK_CYC (TRACK_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_ni    (rst_int_n),
    .restart_i (restart),
    .track_i   (track),
    .tick_o    (tick)
  );

  zcal_core #(
    .CODE_W    (CODE_W),
    .TRACK_CYC (TRACK_CYC),
    .BUDGET    (BUDGET)
  ) u_core (
    .clk          (clk),
    .rst_ni       (rst_int_n),
    .tick_i       (tick),
    .cmp_strong_i (in_sync[0]),
    .strap_i      (in_sync[1]),
    .restart_o    (restart),
    .track_o      (track),
    .code_o       (imp_code_o),
    .done_o       (cal_done_o)
  );

endmodule

// File: tb/test_zcal_ctrl.sv
module test_zcal_ctrl;

  localparam int CW   = 6;
  localparam int STEP = 16;
  localparam int TRK  = 32;
  localparam int SYNC = 2;
  localparam int DONE_EDGE = SYNC + CW * STEP;
  localparam int NVEC = 8;
  // target, code after first decision, final code
  localparam int VEC [0:NVEC-1][0:2] = '{
    '{0, 16, 0}, '{63, 48, 63}, '{32, 48, 32}, '{31, 16, 31},
    '{1, 16, 1}, '{62, 48, 62}, '{21, 16, 21}, '{42, 48, 42}
  };

  logic          clk;
  logic          rst_n;
  logic          strap;
  logic [1:0]    mode;   // 0 model, 1 always strong, 2 always weak
  logic [CW-1:0] target;
  logic [CW-1:0] code;
  logic          done;
  logic          cmp;
  int nchk;
  int nfail;

  assign cmp = (mode == 2'd0) ? (code > target) : (mode == 2'd1);

  zcal_ctrl #(
    .CODE_W(CW), .STEP_CYC(STEP), .TRACK_CYC(TRK), .SYNC_STAGES(SYNC), .BUDGET(1024)
  ) i_zcal_ctrl (
    .clk(clk), .rst_n(rst_n), .cmp_strong_i(cmp), .ref_tied_hi_i(strap),
    .imp_code_o(code), .cal_done_o(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "code in reset", int'(code), 32);
    chk("R1", "done in reset", int'(done), 0);
    rst_n = 1'b1;
  endtask

  task automatic search_to_done(input int t);
    target = CW'(t);
    mode   = 2'd0;
    do_reset();
    adv(DONE_EDGE);
    chk("R2", "final code", int'(code), t);
    chk("R3", "done after search", int'(done), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL all: watchdog expired actual=%0d expected=%0d", nchk, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    nchk   = 0;
    nfail  = 0;
    rst_n  = 1'b0;
    strap  = 1'b0;
    mode   = 2'd0;
    target = '0;

    // Table walk: search result for several targets
    for (int v = 0; v < NVEC; v++) begin
      target = CW'(VEC[v][0]);
      mode   = 2'd0;
      do_reset();
      adv(SYNC + STEP - 1);
      chk("R1", "code before first decision", int'(code), 32);
      adv(1);
      chk("R2", "code after first decision", int'(code), VEC[v][1]);
      adv(DONE_EDGE - SYNC - STEP - 1);
      chk("R3", "done one edge early", int'(done), 0);
      adv(1);
      chk("R3", "done at end of search", int'(done), 1);
      chk("R2", "final code", int'(code), VEC[v][2]);
    end

    // R4: single steps at the tracking interval
    search_to_done(10);
    mode = 2'd2;
    adv(TRK - 1);
    chk("R4", "no move inside interval", int'(code), 10);
    adv(1);
    chk("R4", "step up on weak", int'(code), 11);
    adv(TRK);
    chk("R4", "second step up", int'(code), 12);
    mode = 2'd1;
    adv(TRK);
    chk("R4", "step down on strong", int'(code), 11);
    chk("R3", "done held in tracking", int'(done), 1);

    // R5: saturation at both ends
    search_to_done(63);
    mode = 2'd2;
    adv(2 * TRK);
    chk("R5", "saturate high", int'(code), 63);
    search_to_done(0);
    mode = 2'd1;
    adv(2 * TRK);
    chk("R5", "saturate low", int'(code), 0);
    chk("R3", "done held at floor", int'(done), 1);

    // R6 / R7: strap forcing and release
    search_to_done(21);
    strap = 1'b1;
    mode  = 2'd1;
    adv(SYNC + 1);
    chk("R6", "forced code", int'(code), 63);
    chk("R6", "done while forced", int'(done), 1);
    adv(3 * TRK);
    chk("R6", "comparator ignored", int'(code), 63);
    strap = 1'b0;
    mode  = 2'd0;
    adv(SYNC + 1);
    chk("R7", "code back at mid", int'(code), 32);
    chk("R7", "done cleared", int'(done), 0);
    adv(CW * STEP - 1);
    chk("R7", "done one edge early", int'(done), 0);
    adv(1);
    chk("R7", "done after new search", int'(done), 1);
    chk("R7", "code after new search", int'(code), 21);

    // R6: strap high across reset release
    strap  = 1'b1;
    target = CW'(5);
    do_reset();
    adv(2 * SYNC);
    chk("R6", "not yet forced", int'(code), 32);
    adv(1);
    chk("R6", "forced after reset", int'(code), 63);
    chk("R6", "done forced after reset", int'(done), 1);
    strap = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule